// File: doc/BRIEF.md
# Paged Write Load Controller

This block models how a byte-wide, page-organised nonvolatile memory takes in writes from a clocked bus with three active-low strobes: chip select, output gate and write strobe. The host loads one or more bytes that lie in the same 64-byte page. The block holds each byte in a page buffer and records which slots have been filled. A write burst ends when no new load begins within a window of `WINDOW_CYC` clock cycles. The window is measured from the start of the most recent accepted load.

When the window closes, the block enters a self-timed programming phase that lasts `PROG_CYC` cycles. While it runs, the block drives `busy` and ignores every write strobe. At the end of the phase, only the buffered bytes are copied into the storage array. All other locations in that page keep their old contents.

Reads take one cycle and return array contents at any time. A byte that has been loaded but not yet committed is not visible to reads. The array is a small register store of `2**(STORE_PAGE_W+6)` bytes, addressed by the low bits of the address.

Top module: `nvpage_ctrl`

## Requirements
- R1: A write strobe is recognised only while `ce_n`=0, `we_n`=0 and `oe_n`=1. Strobing `we_n` low with `oe_n` low, or with `ce_n` high, writes nothing.
- R2: The address is taken in the first cycle in which the write condition of R1 holds. The data byte is taken in the first cycle in which that condition no longer holds. A change of `addr` after the first cycle has no effect.
- R3: `addr[5:0]` selects the byte within a page and `addr[14:6]` is the page number. A load whose page number differs from that of the first byte of the burst is ignored and does not restart the window.
- R4: `busy` rises exactly `WINDOW_CYC` clock edges after the edge on which the last accepted load started. A load accepted inside the window restarts the count.
- R5: `busy` stays high for exactly `PROG_CYC` cycles. The buffered bytes are committed on the edge where it falls.
- R6: While `busy` is high, write strobes are ignored. They neither change the array nor start a new burst.
- R7: Only the byte slots loaded in a burst change in the array, and the other bytes of the page keep their values. A burst may load 1 to 64 bytes, and a repeated load of the same slot keeps the last data.
- R8: With `ce_n`=0 and `oe_n`=0, one edge later `dout_en`=1 and `dout` is the array byte at `addr[LOC_W-1:0]`. This holds during loading and during `busy` as well, when the old contents are returned.
- R9: When `ce_n` or `oe_n` is high, one edge later `dout_en`=0 and `dout`=0.
- R10: After reset, `busy`=0, `dout_en`=0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address; bits 5:0 slot, upper bits page |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data, zero when not driven |
| dout_en | output | 1 | Read data valid / output drive enable |
| busy | output | 1 | Programming phase in progress |

## Verification
Every result is due at a fixed edge. Read data and `dout_en` follow the strobes by one edge. `busy` rises on the `WINDOW_CYC`-th edge after the start edge of the last accepted load, and it falls `PROG_CYC` edges after that, at which point committed bytes become readable.

The bench drives and samples on the falling clock edge. It counts the rising edges between a stimulus and its check, so the window and busy checks land on the last cycle before each transition and on the first cycle after it. Tests that check that something is ignored then read the affected locations back through the normal read path.

// File: rtl/nvpage_pkg.sv
package nvpage_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } nvp_state_t;
endpackage

// File: rtl/nvpage_strobe.sv
module nvpage_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_start,
  output logic wr_end,
  output logic rd_req
);
  logic wr_lvl;
  logic wr_q;
  logic wr_d;

  // write condition: select and strobe low, output gate high (R1)
  assign wr_lvl = ~ce_n & ~we_n & oe_n;
  assign wr_d   = wr_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_d;
  end

  // later of the two falling strobes opens, first rising closes (R2)
  assign wr_start = wr_lvl & ~wr_q;
  assign wr_end   = ~wr_lvl & wr_q;
  assign rd_req   = ~ce_n & ~oe_n;
endmodule

// File: rtl/nvpage_seq.sv
module nvpage_seq
  import nvpage_pkg::*;
#(
  parameter int WINDOW_CYC   = 5000,
  parameter int PROG_CYC     = 250000,
  parameter int PAGE_W       = 9,
  parameter int STORE_PAGE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_start,
  input  logic                    wr_end,
  input  logic [PAGE_W-1:0]       page_in,
  output logic                    load_take,
  output logic                    data_take,
  output logic                    commit,
  output logic                    busy,
  output logic [STORE_PAGE_W-1:0] page_lo
);
  localparam int TMR_W  = (WINDOW_CYC > 2) ? $clog2(WINDOW_CYC) : 1;
  localparam int PCNT_W = (PROG_CYC > 2) ? $clog2(PROG_CYC) : 1;

  nvp_state_t        state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              pend_q, pend_d;
  logic              accept;
  logic              win_done;
  logic              prog_done;

  // accept a load when idle, or in a burst to the same page (R3, R6)
  assign accept    = wr_start &&
                     ((state_q == ST_IDLE) ||
                      ((state_q == ST_LOAD) && (page_in == page_q)));
  assign win_done  = (tmr_q == TMR_W'(WINDOW_CYC - 1));
  assign prog_done = (state_q == ST_PROG) && (pcnt_q == PCNT_W'(PROG_CYC - 1));

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    pcnt_d  = pcnt_q;
    page_d  = page_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_LOAD;
          tmr_d   = '0;
          page_d  = page_in;
          pend_d  = 1'b1;
        end
      end
      ST_LOAD: begin
        if (accept) begin
          tmr_d  = '0;
          pend_d = 1'b1;
        end else begin
          if (wr_end) pend_d = 1'b0;
          if (!win_done) begin
            tmr_d = tmr_q + 1'b1;
          end else if (!pend_q) begin
            state_d = ST_PROG;
            pcnt_d  = '0;
          end
        end
      end
      ST_PROG: begin
        if (prog_done) state_d = ST_IDLE;
        else           pcnt_d  = pcnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      pcnt_q  <= '0;
      page_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      pcnt_q  <= pcnt_d;
      page_q  <= page_d;
      pend_q  <= pend_d;
    end
  end

  assign load_take = accept;
  assign data_take = wr_end && pend_q && (state_q == ST_LOAD);
  assign commit    = prog_done;
  assign busy      = (state_q == ST_PROG);
  assign page_lo   = page_q[STORE_PAGE_W-1:0];

  // R4: programming is entered only from a finished, timed-out burst
  assert_busy_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(state_q) == ST_LOAD) && !$past(pend_q) && $past(win_done));

  // R5: busy drops only after the full programming count
  assert_prog_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(pcnt_q) == PCNT_W'(PROG_CYC - 1)));

  // R6: a strobe seen while busy leaves the burst page alone
  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_start) |=> $stable(page_q));

  // R3: page number is fixed for the whole burst
  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LOAD) && ($past(state_q) == ST_LOAD)) |-> $stable(page_q));
endmodule

// File: rtl/nvpage_buffer.sv
module nvpage_buffer #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_take,
  input  logic                               data_take,
  input  logic                               commit,
  input  logic [IDX_W-1:0]                   idx_in,
  input  logic [DATA_W-1:0]                  din,
  output logic [(2**IDX_W)*DATA_W-1:0]       buf_flat,
  output logic [2**IDX_W-1:0]                mask
);
  localparam int PAGE_BYTES = 2 ** IDX_W;

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb idx_d = load_take ? idx_in : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic              slot_we;
    logic [DATA_W-1:0] data_q;
    logic              vld_q, vld_d;

    assign slot_we = data_take && (idx_q == IDX_W'(g));

    always_comb begin
      vld_d = vld_q;
      if (commit)       vld_d = 1'b0;
      else if (slot_we) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (slot_we) data_q <= din;
        vld_q <= vld_d;
      end
    end

    assign buf_flat[g*DATA_W +: DATA_W] = data_q;
    assign mask[g]                      = vld_q;
  end

  // R7: every slot mark is gone after a commit
  assert_mask_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> (mask == '0));
endmodule

// File: rtl/nvpage_array.sv
module nvpage_array #(
  parameter int IDX_W        = 6,
  parameter int STORE_PAGE_W = 2,
  parameter int DATA_W       = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               commit,
  input  logic [STORE_PAGE_W-1:0]            page_lo,
  input  logic [(2**IDX_W)*DATA_W-1:0]       buf_flat,
  input  logic [2**IDX_W-1:0]                mask,
  input  logic                               rd_req,
  input  logic [STORE_PAGE_W+IDX_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]                  dout,
  output logic                               dout_en
);
  localparam int PAGE_BYTES = 2 ** IDX_W;
  localparam int DEPTH      = 2 ** (STORE_PAGE_W + IDX_W);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              en_q, en_d;

  // commit writes only marked slots of the burst page (R7)
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if ((page_lo == STORE_PAGE_W'(i / PAGE_BYTES)) && mask[i % PAGE_BYTES])
        mem_d[i] = buf_flat[(i % PAGE_BYTES)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  // registered read port (R8, R9)
  always_comb begin
    en_d   = rd_req;
    dout_d = rd_req ? mem_q[rd_addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      en_q   <= 1'b0;
    end else begin
      dout_q <= dout_d;
      en_q   <= en_d;
    end
  end

  assign dout    = dout_q;
  assign dout_en = en_q;

  // R9: undriven bus carries zero
  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
endmodule

// File: rtl/nvpage_ctrl.sv
module nvpage_ctrl #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int IDX_W        = 6,
  parameter int STORE_PAGE_W = 2,
  parameter int WINDOW_CYC   = 5000,
  parameter int PROG_CYC     = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int PAGE_W     = ADDR_W - IDX_W;
  localparam int LOC_W      = STORE_PAGE_W + IDX_W;
  localparam int PAGE_BYTES = 2 ** IDX_W;

  logic rst_meta_q, rst_sync_q;
  logic wr_start, wr_end, rd_req;
  logic load_take, data_take, commit;
  logic [STORE_PAGE_W-1:0]        page_lo;
  logic [PAGE_BYTES*DATA_W-1:0]   buf_flat;
  logic [PAGE_BYTES-1:0]          mask;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  nvpage_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .wr_start (wr_start),
    .wr_end   (wr_end),
    .rd_req   (rd_req)
  );

  nvpage_seq #(
    .WINDOW_CYC   (WINDOW_CYC),
    .PROG_CYC     (PROG_CYC),
    .PAGE_W       (PAGE_W),
    .STORE_PAGE_W (STORE_PAGE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_start  (wr_start),
    .wr_end    (wr_end),
    .page_in   (addr[ADDR_W-1:IDX_W]),
    .load_take (load_take),
    .data_take (data_take),
    .commit    (commit),
    .busy      (busy),
    .page_lo   (page_lo)
  );

  nvpage_buffer #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_buffer (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_take (load_take),
    .data_take (data_take),
    .commit    (commit),
    .idx_in    (addr[IDX_W-1:0]),
    .din       (din),
    .buf_flat  (buf_flat),
    .mask      (mask)
  );

  nvpage_array #(
    .IDX_W        (IDX_W),
    .STORE_PAGE_W (STORE_PAGE_W),
    .DATA_W       (DATA_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .commit   (commit),
    .page_lo  (page_lo),
    .buf_flat (buf_flat),
    .mask     (mask),
    .rd_req   (rd_req),
    .rd_addr  (addr[LOC_W-1:0]),
    .dout     (dout),
    .dout_en  (dout_en)
  );
endmodule

// File: tb/nvpage_ctrl_test.sv
module nvpage_ctrl_test;
  localparam int W = 20;
  localparam int P = 30;

  logic        clk;
  logic        rst_n;
  logic        ce_n, oe_n, we_n;
  logic [14:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // {address, data} burst to page 1, no repeated slot
  localparam logic [22:0] WR_VEC [6] = '{
    {15'h0040, 8'h10}, {15'h007F, 8'hFF}, {15'h0045, 8'h5A},
    {15'h0060, 8'hC3}, {15'h0041, 8'h81}, {15'h005E, 8'h3C}
  };

  nvpage_ctrl #(.WINDOW_CYC(W), .PROG_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive at a falling edge; start seen at next rising edge, end one later
  task automatic write_byte(input logic [14:0] a, input logic [7:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic read_byte(input logic [14:0] a, output logic [7:0] d, output logic en);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_byte(input string req, input logic [14:0] a, input logic [7:0] e);
    logic [7:0] d;
    logic en;
    read_byte(a, d, en);
    chk(req, int'(en), 1);
    chk(req, int'(d), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic en;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);

    // R10: reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 dout_en", int'(dout_en), 0);
    expect_byte("R10 array zero", 15'h0005, 8'h00);

    // table-driven burst to one page (R7, R3 slot index)
    for (int k = 0; k < 6; k++) begin
      write_byte(WR_VEC[k][22:8], WR_VEC[k][7:0]);
      cyc(2);
    end
    cyc(W + P + 5);
    for (int k = 0; k < 6; k++)
      expect_byte("R7 burst byte", WR_VEC[k][22:8], WR_VEC[k][7:0]);
    expect_byte("R7 untouched slot", 15'h0042, 8'h00);

    // R4/R5/R8: single load timing
    write_byte(15'h0005, 8'hA5);
    cyc(W - 1);
    chk("R4 busy before window", int'(busy), 0);
    cyc(1);
    chk("R4 busy at window", int'(busy), 1);
    read_byte(15'h0005, d, en);
    chk("R8 read during busy en", int'(en), 1);
    chk("R8 read during busy old data", int'(d), 0);
    cyc(P - 3);
    chk("R5 busy last cycle", int'(busy), 1);
    cyc(1);
    chk("R5 busy cleared", int'(busy), 0);
    expect_byte("R5 committed", 15'h0005, 8'hA5);

    // R9: bus quiet when a strobe is high
    addr = 15'h0005; ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R9 ce high en", int'(dout_en), 0);
    chk("R9 ce high data", int'(dout), 0);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk("R9 oe high en", int'(dout_en), 0);
    ce_n = 1'b1;
    @(negedge clk);

    // R3: other-page load ignored and does not restart the window
    write_byte(15'h0080, 8'h11);
    cyc(1);
    write_byte(15'h00C1, 8'h22);
    cyc(W - 3);
    chk("R3 window not restarted pre", int'(busy), 0);
    cyc(1);
    chk("R3 window not restarted", int'(busy), 1);
    cyc(P + 3);
    expect_byte("R3 other page ignored", 15'h00C1, 8'h00);
    expect_byte("R3 first page byte", 15'h0080, 8'h11);

    // R4: load inside the window extends it
    write_byte(15'h0084, 8'h21);
    cyc(W - 3);
    write_byte(15'h0085, 8'h22);
    cyc(2);
    chk("R4 window extended", int'(busy), 0);
    cyc(W + P + 5);
    expect_byte("R4 first of extended", 15'h0084, 8'h21);
    expect_byte("R4 second of extended", 15'h0085, 8'h22);

    // R6: write while busy ignored, busy length unchanged
    write_byte(15'h0090, 8'h33);
    cyc(W);
    chk("R6 busy", int'(busy), 1);
    write_byte(15'h0091, 8'h44);
    cyc(P - 2);
    chk("R6 busy length kept", int'(busy), 1);
    cyc(1);
    chk("R6 busy fell", int'(busy), 0);
    cyc(W + 5);
    chk("R6 no new burst", int'(busy), 0);
    expect_byte("R6 busy write ignored", 15'h0091, 8'h00);
    expect_byte("R6 burst byte", 15'h0090, 8'h33);

    // R1: strobe with output gate low, or select high, writes nothing
    addr = 15'h00A8; din = 8'h77; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cyc(W + 3);
    chk("R1 no busy", int'(busy), 0);
    expect_byte("R1 no write", 15'h00A8, 8'h00);

    // R2: address from first cycle, data from the closing edge
    addr = 15'h00A0; din = 8'h55; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    addr = 15'h00A1; din = 8'h66;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    cyc(W + P + 5);
    expect_byte("R2 addr latched early", 15'h00A0, 8'h66);
    expect_byte("R2 later addr unused", 15'h00A1, 8'h00);

    // R7: repeated slot keeps last data
    write_byte(15'h00B0, 8'h01);
    cyc(2);
    write_byte(15'h00B0, 8'h02);
    cyc(W + P + 5);
    expect_byte("R7 last load wins", 15'h00B0, 8'h02);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule